// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Sequencer

This block runs the complete programming flow for a word-addressed one-time-programmable array. It steps through every address, drives the word to be written, and issues timed program pulses while it requests raised programming supply levels. It compares what the array reads back against the intended word. At the end it reports whether the whole device is good or bad.

The flow has three passes. The first pass is blind: each address gets exactly one pulse, and nothing is read back. The second pass verifies each address. A word that reads back wrong gets extra pulses, and each extra pulse is followed by a new verify, up to a fixed retry limit. A word that still fails at the limit stops the run. The third pass starts after the supply request has been dropped to normal read levels. It reads and compares every word once more.

The data source is a combinational port: the block presents an address and receives the expected word for it. The pulse width and the setup and hold windows are given in microseconds and turned into clock cycles with a clock-frequency parameter.

Top module: `otp_prog_seq`

## Requirements
- R1: A rising request on `start` is taken only while `busy` is low. Taking it clears `done` and `fail` and raises `busy` in the next cycle. A `start` seen while `busy` is high has no effect on the running sequence.
- R2: While `rst_n` is low, and after reset, `busy`, `done`, `fail`, `pgm_pulse`, `supply_prog` and `supply_read` are all low. A reset during a run abandons that run.
- R3: `supply_prog` is high from the cycle after a start is taken until the verify pass ends. `pgm_pulse` is only ever high while `supply_prog` is high. `supply_read` is high only during the final compare. The two supply selects are never high together.
- R4: In the first pass, addresses 0 to DEPTH-1 each receive exactly one pulse, in ascending order, with no read-back in between.
- R5: Every program pulse lasts exactly PULSE_US*CLK_MHZ cycles.
- R6: The address and write data are stable for at least SETUP_US*CLK_MHZ cycles before a pulse rises, for the whole pulse, and for at least HOLD_US*CLK_MHZ cycles after it falls.
- R7: In the verify pass, a word whose read-back differs from the expected word gets one more pulse and is then verified again. This repeats for at most MAX_RETRY extra pulses per address.
- R8: If a word still differs after MAX_RETRY extra pulses, the run stops. `fail` goes high and `fail_addr` holds that address. No further pulses follow, and the final compare is skipped.
- R9: Once all words have verified, the final compare reads every address at normal supply levels. The first mismatching address sets `fail` and `fail_addr` and ends the run. If all words match, the run ends with `fail` low.
- R10: At the end of a run, `done` goes high and `busy` goes low. `done`, `fail` and `fail_addr` then hold their values until the next start is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request to begin a programming run |
| exp_data | input | DW | Expected word for the address on `arr_addr` |
| rd_data | input | DW | Word read back from the array at `arr_addr` |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Word to be programmed |
| pgm_pulse | output | 1 | Program pulse strobe |
| supply_prog | output | 1 | Request for raised programming supply levels |
| supply_read | output | 1 | Request for normal read levels during the final compare |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| fail | output | 1 | The last run found a bad word |
| fail_addr | output | AW | Address of the bad word |

## Verification
The embedded assertions check the cycle-level rules at every clock edge: the exact pulse width, address stability during a pulse and in the cycle after it, that pulses occur only under the programming supply, that the two supply selects exclude each other, that the retry count stays bounded, and that the completion flags are consistent with `busy`. Other behaviour only shows up across a whole scenario, so the bench scenarios cover it. That includes the ascending order of the blind pass, the number of pulses each address receives, the outcome at exactly the retry limit and one pulse beyond it, skipping the final compare after a verify failure, a mismatch that appears only at read levels, and the handling of start and reset during a run.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_VERIFY = 3'd4,
        ST_FINAL  = 3'd5
    } seq_state_e;

    typedef enum logic {
        PH_BLIND  = 1'b0,
        PH_CHECK  = 1'b1
    } seq_phase_e;

endpackage

// File: rtl/otp_cyc_timer.sv
module otp_cyc_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/otp_retry_ctr.sv
module otp_retry_ctr #(
    parameter int MAX_RETRY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(MAX_RETRY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == CW'(MAX_RETRY));

    // R7: the extra-pulse count for one address never passes the limit
    assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_RETRY));

    // R8: the sequencer never asks for a pulse beyond the limit
    assert_no_inc_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);

endmodule

// File: rtl/otp_word_cmp.sv
module otp_word_cmp #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] got,
    input  logic [DW-1:0] want,
    output logic          match
);

    logic [DW-1:0] diff;

    always_comb begin
        diff  = got ^ want;
        match = (diff == '0);
    end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int DEPTH     = 65536,
    parameter int DW        = 16,
    parameter int CLK_MHZ   = 50,
    parameter int PULSE_US  = 50,
    parameter int SETUP_US  = 2,
    parameter int HOLD_US   = 2,
    parameter int MAX_RETRY = 10,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] exp_data,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          pgm_pulse,
    output logic          supply_prog,
    output logic          supply_read,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);

    localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;
    localparam int HOLD_CYC  = HOLD_US * CLK_MHZ;
    localparam int MAX_SH    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_CYC   = (PULSE_CYC > MAX_SH) ? PULSE_CYC : MAX_SH;
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [TW-1:0] LD_SETUP  = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] LD_PULSE  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_HOLD   = TW'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        seq_phase_e    ph;
        logic [AW-1:0] addr;
        logic          done;
        logic          fail;
        logic [AW-1:0] faddr;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          rc_clr, rc_inc, rc_limit;
    logic          word_ok;
    logic          at_last;

    otp_cyc_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    otp_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rc_clr),
        .inc      (rc_inc),
        .at_limit (rc_limit)
    );

    otp_word_cmp #(.DW(DW)) u_cmp (
        .got   (rd_data),
        .want  (exp_data),
        .match (word_ok)
    );

    assign at_last = (r_q.addr == LAST_ADDR);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rc_clr   = 1'b0;
        rc_inc   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_SETUP;
                    r_d.ph    = PH_BLIND;
                    r_d.addr  = '0;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.faddr = '0;
                    rc_clr    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    r_d.st   = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    r_d.st   = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    if (r_q.ph == PH_CHECK) begin
                        r_d.st = ST_VERIFY;
                    end else if (at_last) begin
                        r_d.st   = ST_VERIFY;
                        r_d.ph   = PH_CHECK;
                        r_d.addr = '0;
                        rc_clr   = 1'b1;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.addr = r_q.addr + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SETUP;
                    end
                end
            end
            ST_VERIFY: begin
                if (word_ok) begin
                    rc_clr = 1'b1;
                    if (at_last) begin
                        r_d.st   = ST_FINAL;
                        r_d.addr = '0;
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end else if (rc_limit) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fail  = 1'b1;
                    r_d.faddr = r_q.addr;
                end else begin
                    r_d.st   = ST_SETUP;
                    rc_inc   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
            end
            ST_FINAL: begin
                if (!word_ok) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fail  = 1'b1;
                    r_d.faddr = r_q.addr;
                end else if (at_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_BLIND, addr: '0, done: 1'b0,
                     fail: 1'b0, faddr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign arr_addr    = r_q.addr;
    assign arr_wdata   = exp_data;
    assign pgm_pulse   = (r_q.st == ST_PULSE);
    assign supply_prog = (r_q.st == ST_SETUP) || (r_q.st == ST_PULSE) ||
                         (r_q.st == ST_HOLD)  || (r_q.st == ST_VERIFY);
    assign supply_read = (r_q.st == ST_FINAL);
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign fail        = r_q.fail;
    assign fail_addr   = r_q.faddr;

    // Checker state: length of the current pulse run
    logic [31:0] pw_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= '0;
        end else if (pgm_pulse) begin
            pw_q <= pw_q + 1'b1;
        end else begin
            pw_q <= '0;
        end
    end

    // R3: pulses only under the programming supply
    assert_pulse_under_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_pulse |-> supply_prog);

    // R3: the two supply requests exclude each other
    assert_supply_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_prog && supply_read));

    // R5: no pulse runs longer than the set width
    assert_pulse_not_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pw_q <= 32'(PULSE_CYC));

    // R5: a pulse that ends has lasted exactly the set width
    assert_pulse_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_pulse) |-> (pw_q == 32'(PULSE_CYC)));

    // R6: address and data hold through the pulse and the cycle after it
    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_pulse |=> ($stable(arr_addr) && $stable(arr_wdata)));

    // R10: completion flags agree with the busy indication
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fail_has_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R1: a taken start raises busy and clears the result
    assert_start_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !fail));

endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int AW         = 3;
    localparam int DW         = 16;
    localparam int CLK_MHZ    = 1;
    localparam int PULSE_CYC  = 50;
    localparam int SETUP_CYC  = 2;
    localparam int HOLD_CYC   = 2;
    localparam int MAXR       = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst_n, start;
    logic [DW-1:0] exp_data, rd_data, arr_wdata;
    logic [AW-1:0] arr_addr, fail_addr;
    logic          pgm_pulse, supply_prog, supply_read, busy, done, fail;

    otp_prog_seq #(
        .DEPTH(DEPTH), .DW(DW), .CLK_MHZ(CLK_MHZ), .PULSE_US(50),
        .SETUP_US(2), .HOLD_US(2), .MAX_RETRY(MAXR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_data(exp_data),
        .rd_data(rd_data), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .pgm_pulse(pgm_pulse), .supply_prog(supply_prog),
        .supply_read(supply_read), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr)
    );

    function automatic logic [DW-1:0] golden(input logic [AW-1:0] a);
        return 16'hA5C3 ^ (16'(a) * 16'h1357);
    endfunction

    assign exp_data = golden(arr_addr);

    // Array model: pulses OR bits in; a weak word reads wrong while it has
    // seen no more than w_n pulses; a bad word reads wrong at read levels.
    logic [DW-1:0] mem [DEPTH];
    int            pcnt [DEPTH];
    logic [3:0]    w_addr, w_n, b_addr;
    logic          clr_req;

    always_comb begin
        rd_data = mem[arr_addr];
        if ({1'b0, arr_addr} == w_addr && pcnt[arr_addr] <= int'(w_n))
            rd_data = rd_data ^ 16'h0001;
        if (supply_read && {1'b0, arr_addr} == b_addr)
            rd_data = rd_data ^ 16'h0002;
    end

    int         n_pulses, since_chg, aft, width;
    logic       hold_trk, prev_pulse;
    logic [AW-1:0] prev_addr;
    bit         order_err, setup_err, hold_err, width_err, sup_err, saw_read;

    always @(negedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  = '0;
                pcnt[i] = 0;
            end
            n_pulses = 0; since_chg = 1000; aft = 0; width = 0;
            hold_trk = 1'b0; prev_pulse = 1'b0; prev_addr = arr_addr;
            order_err = 0; setup_err = 0; hold_err = 0; width_err = 0;
            sup_err = 0; saw_read = 0;
        end else begin
            if (arr_addr != prev_addr) begin
                if (hold_trk && aft < HOLD_CYC) hold_err = 1;
                if (prev_pulse && pgm_pulse) setup_err = 1;
                hold_trk  = 1'b0;
                since_chg = 1;
            end else begin
                since_chg++;
                if (hold_trk) aft++;
            end
            if (pgm_pulse && !prev_pulse) begin
                if (since_chg - 1 < SETUP_CYC) setup_err = 1;
                if (n_pulses < DEPTH && int'(arr_addr) != n_pulses) order_err = 1;
                n_pulses++;
                pcnt[arr_addr] = pcnt[arr_addr] + 1;
                mem[arr_addr]  = mem[arr_addr] | arr_wdata;
                width    = 1;
                hold_trk = 1'b0;
            end else if (pgm_pulse) begin
                width++;
            end else if (prev_pulse) begin
                if (width != PULSE_CYC) width_err = 1;
                hold_trk = 1'b1;
                aft      = 1;
            end
            if (pgm_pulse && !supply_prog) sup_err = 1;
            if (supply_prog && supply_read) sup_err = 1;
            if (supply_read) saw_read = 1;
            prev_pulse = pgm_pulse;
            prev_addr  = arr_addr;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    // Scenario table: weak address and its failing pulse count, bad-at-read
    // address (8 = none), expected fail, fail address, total pulses, read pass seen
    typedef struct packed {
        logic [3:0] w;
        logic [3:0] n;
        logic [3:0] b;
        logic       ef;
        logic [3:0] efa;
        logic [7:0] ep;
        logic       er;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'd0,  4'd8, 1'b0, 4'd0, 8'd8,  1'b1},
        '{4'd3, 4'd1,  4'd8, 1'b0, 4'd0, 8'd9,  1'b1},
        '{4'd0, 4'd10, 4'd8, 1'b0, 4'd0, 8'd18, 1'b1},
        '{4'd5, 4'd11, 4'd8, 1'b1, 4'd5, 8'd18, 1'b0},
        '{4'd7, 4'd4,  4'd8, 1'b0, 4'd0, 8'd12, 1'b1},
        '{4'd0, 4'd0,  4'd6, 1'b1, 4'd6, 8'd8,  1'b1},
        '{4'd2, 4'd2,  4'd1, 1'b1, 4'd1, 8'd10, 1'b1},
        '{4'd4, 4'd11, 4'd0, 1'b1, 4'd4, 8'd18, 1'b0}
    };

    task automatic do_run(input logic [3:0] w, input logic [3:0] n,
                          input logic [3:0] b, input bit mid_start);
        w_addr = w; w_n = n; b_addr = b;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 5000; c++) begin
            if (!busy) break;
            if (mid_start && c == 100) start = 1'b1;
            if (mid_start && c == 101) start = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic check_run(input vec_t v, input string tag);
        int exp_extra;
        bit cnt_ok;
        exp_extra = (int'(v.n) > MAXR) ? MAXR : int'(v.n);
        cnt_ok = 1;
        for (int a = 0; a < DEPTH; a++)
            if (pcnt[a] != 1 + ((a == int'(v.w)) ? exp_extra : 0)) cnt_ok = 0;
        chk(done && !busy, {tag, " R10 done"}, int'(done), 1);
        chk(fail == v.ef, {tag, " R9/R8 fail flag"}, int'(fail), int'(v.ef));
        if (v.ef) chk(fail_addr == v.efa[2:0], {tag, " R8/R9 fail_addr"},
                      int'(fail_addr), int'(v.efa));
        chk(n_pulses == int'(v.ep), {tag, " R7 total pulses"}, n_pulses, int'(v.ep));
        chk(cnt_ok, {tag, " R4/R7 per-address pulses"}, int'(cnt_ok), 1);
        chk(saw_read == v.er, {tag, " R8 final compare run"}, int'(saw_read), int'(v.er));
        chk(!order_err, {tag, " R4 blind order"}, int'(order_err), 0);
        chk(!width_err, {tag, " R5 pulse width"}, int'(width_err), 0);
        chk(!setup_err && !hold_err, {tag, " R6 setup/hold"},
            int'(setup_err) + int'(hold_err), 0);
        chk(!sup_err, {tag, " R3 supply selects"}, int'(sup_err), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; clr_req = 1'b1;
        w_addr = 4'd0; w_n = 4'd0; b_addr = 4'd8;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(!busy && !done && !fail && !pgm_pulse && !supply_prog && !supply_read,
            "R2 reset outputs", int'(busy | done | fail | pgm_pulse), 0);
        rst_n = 1'b1;
        clr_req = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            do_run(VECS[i].w, VECS[i].n, VECS[i].b, 1'b0);
            check_run(VECS[i], $sformatf("vec%0d", i));
        end

        // R10: result held after the run ends
        repeat (20) @(negedge clk);
        chk(done && fail && fail_addr == 3'd4, "R10 result held",
            int'(fail_addr), 4);

        // R1: a start taken clears the result and raises busy
        w_addr = 4'd0; w_n = 4'd0; b_addr = 4'd8;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R1 start clears result", int'(busy), 1);
        chk(supply_prog && !supply_read, "R3 prog supply after start",
            int'(supply_prog), 1);
        for (int c = 0; c < 5000; c++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(done && !fail, "R9 clean pass", int'(fail), 0);

        // R1: start while busy is ignored
        do_run(4'd0, 4'd0, 4'd8, 1'b1);
        check_run(VECS[0], "busy-start R1");

        // R2: reset mid-run abandons the run
        w_addr = 4'd0; w_n = 4'd0; b_addr = 4'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !pgm_pulse && !supply_prog && !supply_read && !done,
            "R2 reset during run", int'(busy | pgm_pulse | supply_prog), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy && !pgm_pulse, "R2 stays idle after reset", int'(busy), 0);

        finish_run();
    end

endmodule